// File: doc/BRIEF.md
# SPI Master Transaction Engine

This block runs byte transactions on an SPI bus as the controller side. Software-facing logic elsewhere pushes transmit bytes into a 32-entry queue, loads a 16-bit character count, picks targets with a 4-bit select mask and issues a start strobe. The engine then shifts bytes out in clock mode 0 (clock idles low, data launched on the falling edge, sampled on the rising edge, most significant bit first). The serial clock runs at the system clock divided by `2*HALF`. Each returned byte lands in a 32-entry receive queue that the host drains through a read strobe.

The received data depends on the select mask. With a single target, its data is kept. With several targets, the exchange is a broadcast and nothing is stored. With no target, a fill value of 0xFF is stored for every byte sent. The engine never overfills the receive queue: it stops before starting a byte while that queue is full and resumes once an entry is popped. Select lines are active low. They can stay asserted across transactions, be marked for release at the end of the current one, or all be dropped at once by clearing the enable.

Top module: `spi_xfer_engine`

## Requirements
- R1: Both queues hold 32 bytes and report their fill as 6-bit levels; a transmit write while the transmit queue holds 32 bytes is dropped, the level stays 32, and `tx_ovr_o` pulses high for one cycle on the following clock.
- R2: The serial clock idles low, each high and low phase lasts `HALF` system clocks, a byte takes exactly 8 rising edges, and the most significant bit is sent and received first.
- R3: A start (accepted only while enabled and idle) drives `cs_no` to the bitwise inverse of `sel_mask_i`, which releases lines whose mask bit is 0; the engine sends exactly the loaded count of bytes and pulses `done_o` for one cycle after the last. A count of 0 gives a `done_o` pulse with no byte sent.
- R4: While the receive queue holds 32 bytes no new byte is started, even with transmit data queued; popping one entry lets exactly one more byte go out.
- R5: With one mask bit set, the byte clocked in on that target's `miso_i` bit is stored; with two or more set, nothing is stored; with none set, 0xFF is stored per byte sent.
- R6: At the end of a transaction, a select line is released only if `sel_hold_i` was low in some cycle while that line was asserted; with `sel_hold_i` high throughout, the lines stay asserted after `done_o`.
- R7: Driving `en_i` low aborts any transaction, drives all `cs_no` bits high and stops the serial clock by the next clock edge.
- R8: With `rx_en_i` low, received bytes are discarded, `rx_data_o` reads 0 and a read strobe neither pops nor flags underrun.
- R9: A read strobe on an empty, enabled receive queue pulses `rx_und_o` for one cycle on the following clock.
- R10: `tx_flush_i` and `rx_flush_i` each empty their queue in one clock, so the level reads 0 on the next cycle.
- R11: Bytes written after the start, while the transaction is active, are sent in that same transaction, in write order after the bytes queued before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Controller enable; low releases all select lines and aborts |
| rx_en_i | input | 1 | Receive queue enable |
| tx_wr_i | input | 1 | Transmit byte write strobe |
| tx_data_i | input | 8 | Transmit byte |
| tx_flush_i | input | 1 | Empty the transmit queue |
| rx_rd_i | input | 1 | Receive queue pop strobe |
| rx_data_o | output | 8 | Head of the receive queue (0 when empty or disabled) |
| rx_flush_i | input | 1 | Empty the receive queue |
| cnt_wr_i | input | 1 | Load the character count (ignored while busy) |
| cnt_i | input | 16 | Character count |
| start_i | input | 1 | Start a transaction |
| sel_mask_i | input | 4 | Target select mask |
| sel_hold_i | input | 1 | High keeps select lines asserted after the transaction |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to targets |
| miso_i | input | 4 | Serial data from each target |
| cs_no | output | 4 | Select lines, active low |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle pulse at the end of a transaction |
| tx_level_o | output | 6 | Transmit queue fill |
| rx_level_o | output | 6 | Receive queue fill |
| tx_ovr_o | output | 1 | Transmit overrun pulse |
| rx_und_o | output | 1 | Receive underrun pulse |

## Verification
Each target line returns something different: target 0 echoes the sent data, target 1 its inverse, target 2 all zeros and target 3 all ones. A stored byte therefore shows which line was sampled and in what bit order. Random transactions mix single-target, no-target and broadcast masks, split the bytes between before and after the start, and vary the hold input. This separates the storage rule, the mid-transaction feed and the release marking. Directed cases fill the receive queue to 32 with the count not yet reached to show the stall and the one-byte resume. Others overfill the transmit queue, start with a zero count, read with the receive queue empty or disabled, and drop the enable mid-transfer.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  typedef logic [7:0] byte_t;
  localparam byte_t FILL_BYTE = 8'hFF;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo
  import spi_eng_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  byte_t         wdata_i,
  input  logic          pop_i,
  output byte_t         head_o,
  output logic [CW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o
);
  byte_t         mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_q];
  assign level_o = cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wr_q] <= wdata_i;
  end
endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter
  import spi_eng_pkg::*;
#(
  parameter int HALF = 1,
  localparam int DW = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  abort_i,
  input  logic  load_i,
  input  byte_t data_i,
  input  logic  miso_i,
  output logic  sclk_o,
  output logic  mosi_o,
  output logic  busy_o,
  output logic  done_o,
  output byte_t rx_o
);
  logic          act_q, sclk_q, done_q;
  byte_t         sh_q, rx_q;
  logic [2:0]    bit_q;
  logic [DW-1:0] div_q;
  logic          half_end;

  assign half_end = (div_q == DW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
      sh_q   <= '0;
      rx_q   <= '0;
      bit_q  <= '0;
      div_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        act_q  <= 1'b0;
        sclk_q <= 1'b0;
      end else if (load_i) begin
        act_q  <= 1'b1;
        sh_q   <= data_i;
        sclk_q <= 1'b0;
        div_q  <= '0;
        bit_q  <= '0;
      end else if (act_q) begin
        if (half_end) begin
          div_q <= '0;
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            rx_q   <= {rx_q[6:0], miso_i};
          end else begin
            sclk_q <= 1'b0;
            if (bit_q == 3'd7) begin
              act_q  <= 1'b0;
              done_q <= 1'b1;
            end else begin
              bit_q <= bit_q + 1'b1;
              sh_q  <= {sh_q[6:0], 1'b0};
            end
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = act_q & sh_q[7];
  assign busy_o = act_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;
endmodule

// File: rtl/spi_sel_ctrl.sv
module spi_sel_ctrl #(
  parameter int NSEL = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            start_i,
  input  logic            end_i,
  input  logic [NSEL-1:0] mask_i,
  input  logic            hold_i,
  output logic [NSEL-1:0] cs_act_o
);
  logic [NSEL-1:0] cs_q, mark_q, mark_n;

  // lines seen asserted while hold is low are due for release at the end
  assign mark_n = mark_q | (hold_i ? '0 : cs_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= '0;
      mark_q <= '0;
    end else if (!en_i) begin
      cs_q   <= '0;
      mark_q <= '0;
    end else if (start_i) begin
      cs_q   <= mask_i;
      mark_q <= mark_n & mask_i;
    end else if (end_i) begin
      cs_q   <= cs_q & ~mark_n;
      mark_q <= '0;
    end else begin
      mark_q <= mark_n;
    end
  end

  assign cs_act_o = cs_q;
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_eng_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int NSEL  = 4,
  parameter int CNT_W = 16,
  parameter int HALF  = 1,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            rx_en_i,
  input  logic            tx_wr_i,
  input  logic [7:0]      tx_data_i,
  input  logic            tx_flush_i,
  input  logic            rx_rd_i,
  output logic [7:0]      rx_data_o,
  input  logic            rx_flush_i,
  input  logic            cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic            start_i,
  input  logic [NSEL-1:0] sel_mask_i,
  input  logic            sel_hold_i,
  output logic            sclk_o,
  output logic            mosi_o,
  input  logic [NSEL-1:0] miso_i,
  output logic [NSEL-1:0] cs_no,
  output logic            busy_o,
  output logic            done_o,
  output logic [LW-1:0]   tx_level_o,
  output logic [LW-1:0]   rx_level_o,
  output logic            tx_ovr_o,
  output logic            rx_und_o
);
  logic             active_q, done_q, ovr_q, und_q;
  logic [CNT_W-1:0] cnt_q;
  logic [NSEL-1:0]  cs_act;
  byte_t            tx_head, rx_head, sh_rx, rx_byte;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic             sh_busy, sh_done, sel_miso;
  logic             feed, start_go, zero_go, finish, rx_push, rx_pop;

  spi_byte_fifo #(.DEPTH(DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .flush_i (tx_flush_i),
    .push_i  (tx_wr_i),
    .wdata_i (tx_data_i),
    .pop_i   (feed),
    .head_o  (tx_head),
    .level_o (tx_level_o),
    .full_o  (tx_full),
    .empty_o (tx_empty)
  );

  spi_byte_fifo #(.DEPTH(DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .flush_i (rx_flush_i),
    .push_i  (rx_push),
    .wdata_i (rx_byte),
    .pop_i   (rx_pop),
    .head_o  (rx_head),
    .level_o (rx_level_o),
    .full_o  (rx_full),
    .empty_o (rx_empty)
  );

  assign sel_miso = |(miso_i & cs_act);

  spi_bit_shifter #(.HALF(HALF)) u_shifter (
    .clk_i, .rst_ni,
    .abort_i (!en_i),
    .load_i  (feed),
    .data_i  (tx_head),
    .miso_i  (sel_miso),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o),
    .busy_o  (sh_busy),
    .done_o  (sh_done),
    .rx_o    (sh_rx)
  );

  spi_sel_ctrl #(.NSEL(NSEL)) u_sel (
    .clk_i, .rst_ni,
    .en_i     (en_i),
    .start_i  (start_go),
    .end_i    (finish || zero_go),
    .mask_i   (sel_mask_i),
    .hold_i   (sel_hold_i),
    .cs_act_o (cs_act)
  );

  assign start_go = start_i && en_i && !active_q;
  assign zero_go  = start_go && (cnt_q == '0);
  assign finish   = active_q && en_i && sh_done && (cnt_q == CNT_W'(1));
  // one byte in flight at most; start it only if its result has a slot
  assign feed     = active_q && en_i && !sh_busy && !sh_done && (cnt_q != '0)
                    && !tx_empty && !rx_full;

  assign rx_byte  = (cs_act == '0) ? FILL_BYTE : sh_rx;
  assign rx_push  = active_q && en_i && sh_done && rx_en_i
                    && ((cs_act == '0) || $onehot(cs_act));
  assign rx_pop   = rx_rd_i && rx_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      done_q   <= 1'b0;
      ovr_q    <= 1'b0;
      und_q    <= 1'b0;
    end else begin
      done_q <= en_i && (finish || zero_go);
      ovr_q  <= tx_wr_i && tx_full && !tx_flush_i;
      und_q  <= rx_pop && rx_empty && !rx_flush_i;
      if (!en_i)         active_q <= 1'b0;
      else if (start_go) active_q <= (cnt_q != '0);
      else if (finish)   active_q <= 1'b0;
      if (cnt_wr_i && !active_q)      cnt_q <= cnt_i;
      else if (active_q && sh_done)   cnt_q <= cnt_q - 1'b1;
    end
  end

  assign rx_data_o = (rx_en_i && !rx_empty) ? rx_head : 8'h00;
  assign cs_no     = ~cs_act;
  assign busy_o    = active_q;
  assign done_o    = done_q;
  assign tx_ovr_o  = ovr_q;
  assign rx_und_o  = und_q;
endmodule

// File: rtl/spi_xfer_engine_chk.sv
module spi_xfer_engine_chk #(
  parameter int DEPTH = 32,
  parameter int NSEL  = 4,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            en_i,
  input logic            tx_wr_i,
  input logic            sclk_o,
  input logic [NSEL-1:0] cs_no,
  input logic            busy_o,
  input logic            done_o,
  input logic [LW-1:0]   tx_level_o,
  input logic [LW-1:0]   rx_level_o,
  input logic            tx_ovr_o
);
  assert_no_overflow_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_level_o <= LW'(DEPTH)) && (tx_level_o <= LW'(DEPTH)));

  assert_ovr_when_full_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ovr_o |-> $past(tx_wr_i && (tx_level_o == LW'(DEPTH))));

  assert_sclk_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sclk_o);

  assert_done_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_disable_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cs_no == '1) && !busy_o);
endmodule

bind spi_xfer_engine spi_xfer_engine_chk #(.DEPTH(DEPTH), .NSEL(NSEL)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .tx_wr_i    (tx_wr_i),
  .sclk_o     (sclk_o),
  .cs_no      (cs_no),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .tx_level_o (tx_level_o),
  .rx_level_o (rx_level_o),
  .tx_ovr_o   (tx_ovr_o)
);

// File: tb/spi_xfer_engine_bench.sv
`timescale 1ns/1ps
module spi_xfer_engine_bench;
  localparam int HALF = 1;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       en = 1'b1, rx_en = 1'b1, tx_wr = 1'b0, tx_flush = 1'b0;
  logic [7:0] tx_data = '0, rx_data;
  logic       rx_rd = 1'b0, rx_flush = 1'b0, cnt_wr = 1'b0, start = 1'b0, hold = 1'b1;
  logic [15:0] cnt_v = '0;
  logic [3:0] mask = '0, miso, cs_no;
  logic       sclk, mosi, busy, done, tx_ovr, rx_und;
  logic [5:0] tx_lvl, rx_lvl;

  int checks = 0, errors = 0, cyc = 0;
  int rises = 0, hi_run = 0, width_bad = 0;
  logic sclk_prev = 1'b0;
  logic [7:0] exp_rx[$];

  always #10 clk = ~clk;

  // target models: echo, inverse, all zeros, all ones
  always_comb begin
    miso[0] = mosi;
    miso[1] = ~mosi;
    miso[2] = 1'b0;
    miso[3] = 1'b1;
  end

  spi_xfer_engine #(.HALF(HALF)) u_spi_xfer_engine (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .rx_en_i(rx_en),
    .tx_wr_i(tx_wr), .tx_data_i(tx_data), .tx_flush_i(tx_flush),
    .rx_rd_i(rx_rd), .rx_data_o(rx_data), .rx_flush_i(rx_flush),
    .cnt_wr_i(cnt_wr), .cnt_i(cnt_v), .start_i(start),
    .sel_mask_i(mask), .sel_hold_i(hold),
    .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .cs_no(cs_no),
    .busy_o(busy), .done_o(done), .tx_level_o(tx_lvl), .rx_level_o(rx_lvl),
    .tx_ovr_o(tx_ovr), .rx_und_o(rx_und)
  );

  always @(negedge clk) begin
    if (sclk && !sclk_prev) rises++;
    if (sclk) hi_run++;
    else begin
      if (sclk_prev && hi_run != HALF) width_bad++;
      hi_run = 0;
    end
    sclk_prev = sclk;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] resp(input int k, input logic [7:0] b);
    case (k)
      0: return b;
      1: return ~b;
      2: return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

  // expected receive entry for one byte sent under the given mask
  task automatic model(input logic [7:0] b, input logic [3:0] m);
    if (!rx_en) return;
    if (m == 4'b0000) exp_rx.push_back(8'hFF);
    else if ($countones(m) == 1) begin
      for (int k = 0; k < 4; k++) if (m[k]) exp_rx.push_back(resp(k, b));
    end
  endtask

  task automatic wr_tx(input logic [7:0] b, output logic ovr);
    @(negedge clk); tx_wr = 1'b1; tx_data = b;
    @(negedge clk); tx_wr = 1'b0; ovr = tx_ovr;
  endtask

  task automatic rd_rx(output logic [7:0] b, output logic und);
    @(negedge clk); b = rx_data; rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0; und = rx_und;
  endtask

  task automatic flush_both();
    @(negedge clk); tx_flush = 1'b1; rx_flush = 1'b1;
    @(negedge clk); tx_flush = 1'b0; rx_flush = 1'b0;
    exp_rx.delete();
  endtask

  task automatic load_cnt(input int n);
    @(negedge clk); cnt_wr = 1'b1; cnt_v = 16'(n);
    @(negedge clk); cnt_wr = 1'b0;
  endtask

  task automatic fire();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(cs_no == ~mask, "R3", "select lines after start", cs_no, ~mask);
  endtask

  task automatic wait_done(output bit got);
    got = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      if (done) begin got = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic drain(input string req);
    logic [7:0] b; logic u;
    check(rx_lvl == 6'(exp_rx.size()), req, "rx level", rx_lvl, exp_rx.size());
    while (exp_rx.size() > 0 && rx_lvl != 0) begin
      logic [7:0] e;
      e = exp_rx.pop_front();
      rd_rx(b, u);
      check(b == e, req, "rx byte", b, e);
    end
  endtask

  task automatic xfer(input logic [3:0] m, input int n, input int pre, input logic h);
    logic [7:0] bytes[8]; logic o; bit got;
    mask = m; hold = h;
    rises = 0; width_bad = 0;
    for (int i = 0; i < n; i++) bytes[i] = 8'($urandom);
    load_cnt(n);
    for (int i = 0; i < pre; i++) begin wr_tx(bytes[i], o); model(bytes[i], m); end
    fire();
    for (int i = pre; i < n; i++) begin wr_tx(bytes[i], o); model(bytes[i], m); end
    wait_done(got);
    check(got, "R3", "done pulse", got, 1);
    @(negedge clk);
    check(rises == 8 * n, "R2", "rising edges", rises, 8 * n);
    check(width_bad == 0, "R2", "clock phase width", width_bad, 0);
    check(cs_no == (h ? ~m : 4'hF), "R6", "select lines after end", cs_no, h ? ~m : 4'hF);
    drain((pre < n) ? "R11" : "R5");
  endtask

  initial begin
    logic [7:0] b; logic u, o; bit got; int ovr_seen;
    logic [3:0] masks[6];
    masks = '{4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0000, 4'b0101};
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(cs_no == 4'hF && !sclk && !busy && !done, "R2", "reset idle",
          {cs_no, sclk, busy, done}, {4'hF, 3'b000});
    check(tx_lvl == 0 && rx_lvl == 0, "R1", "reset levels", {tx_lvl, rx_lvl}, 0);

    // directed: single targets, broadcast, no target
    xfer(4'b0001, 4, 4, 1'b1);
    xfer(4'b0010, 6, 2, 1'b0);
    xfer(4'b0101, 3, 3, 1'b1);
    check(rx_lvl == 0, "R5", "broadcast stores nothing", rx_lvl, 0);
    xfer(4'b0000, 3, 1, 1'b0);
    xfer(4'b1000, 2, 0, 1'b0);

    // zero count
    mask = 4'b0100; hold = 1'b1;
    load_cnt(0);
    fire();
    wait_done(got);
    check(got && !busy && rx_lvl == 0, "R3", "zero count done", {got, busy, rx_lvl}, 8'h80);

    // receive back-pressure
    flush_both();
    mask = 4'b0001; hold = 1'b1;
    load_cnt(40);
    for (int i = 0; i < 32; i++) begin b = 8'(i * 7 + 3); wr_tx(b, o); model(b, mask); end
    fire();
    repeat (1200) @(negedge clk);
    check(rx_lvl == 32 && busy && tx_lvl == 0, "R4", "stall at full",
          {rx_lvl, busy, tx_lvl}, {6'd32, 1'b1, 6'd0});
    for (int i = 32; i < 40; i++) begin b = 8'(i * 7 + 3); wr_tx(b, o); model(b, mask); end
    repeat (100) @(negedge clk);
    check(tx_lvl == 8, "R4", "no shift while full", tx_lvl, 8);
    rd_rx(b, u);
    check(b == exp_rx.pop_front(), "R4", "first stalled byte", b, 3);
    repeat (100) @(negedge clk);
    check(rx_lvl == 32 && tx_lvl == 7, "R4", "one byte resumes", {rx_lvl, tx_lvl}, {6'd32, 6'd7});
    for (int i = 0; i < 200 && busy; i++) begin
      logic [7:0] e;
      e = exp_rx.pop_front();
      rd_rx(b, u);
      check(b == e, "R4", "byte during drain", b, e);
      repeat (20) @(negedge clk);
    end
    check(!busy, "R4", "transaction completes", busy, 0);
    drain("R4");

    // transmit overrun and flush
    ovr_seen = 0;
    for (int i = 0; i < 33; i++) begin wr_tx(8'(i), o); if (o) ovr_seen++; end
    check(tx_lvl == 32 && ovr_seen == 1, "R1", "overrun on 33rd write",
          {tx_lvl, 8'(ovr_seen)}, {6'd32, 8'd1});
    @(negedge clk); tx_flush = 1'b1;
    @(negedge clk); tx_flush = 1'b0;
    check(tx_lvl == 0, "R10", "transmit flush", tx_lvl, 0);

    // underrun
    rd_rx(b, u);
    check(u == 1'b1 && b == 8'h00, "R9", "underrun pulse", {u, b}, 9'h100);

    // receive disabled
    rx_en = 1'b0;
    xfer(4'b0001, 3, 3, 1'b0);
    check(rx_lvl == 0, "R8", "disabled discards", rx_lvl, 0);
    rd_rx(b, u);
    check(b == 8'h00 && !u, "R8", "disabled read", {u, b}, 0);
    rx_en = 1'b1;

    // receive flush
    xfer(4'b0000, 2, 2, 1'b0);
    xfer(4'b0000, 0, 0, 1'b0);
    mask = 4'b0001; hold = 1'b1;
    load_cnt(3);
    for (int i = 0; i < 3; i++) wr_tx(8'h5A, o);
    fire();
    wait_done(got);
    check(rx_lvl == 3, "R10", "bytes before rx flush", rx_lvl, 3);
    @(negedge clk); rx_flush = 1'b1;
    @(negedge clk); rx_flush = 1'b0;
    check(rx_lvl == 0, "R10", "receive flush", rx_lvl, 0);

    // disable mid-transfer
    mask = 4'b0010; hold = 1'b1;
    load_cnt(5);
    for (int i = 0; i < 5; i++) wr_tx(8'hC3, o);
    fire();
    repeat (20) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check(cs_no == 4'hF && !busy && !sclk, "R7", "disable releases",
          {cs_no, busy, sclk}, {4'hF, 2'b00});
    en = 1'b1;
    flush_both();

    // random transactions
    for (int it = 0; it < 16; it++) begin
      int n, pre;
      n   = 1 + int'($urandom % 8);
      pre = int'($urandom % (n + 1));
      xfer(masks[$urandom % 6], n, pre, 1'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule